// File: doc/BRIEF.md
# Mode-filtered performance counter unit

This block holds a small bank of 32-bit event counters for a processor core. Each counter has a control word beside it. The control word chooses one of the counter's event inputs and lists the privilege levels in which counting is allowed. On every clock, a counter adds one when two things are true: its selected event input is high, and the core's current privilege state matches at least one of the levels enabled in its control word. Software reads and writes both the control words and the counts through a single-cycle register port. Reads are combinational. Writes take effect at the next clock edge.

Overflow means that the top bit of a counter is set. It does not mean wrap-around. A counter whose top bit is set and whose interrupt enable is on holds the interrupt request high. The same condition is reflected into a single pending bit of a cause-register image. The level stays high until software writes the count back with the top bit cleared. Each control word has a top bit that reads 1 while a higher-numbered counter exists, so software can probe the control words in order to learn how many counters are present. The parameter NUM_CNT (1 to 4) sets how many counters are built. Indices above it behave as empty slots.

Top module: `perf_count_unit`

## Requirements
- R1: After reset, every count and every control field is zero, irq_o is low and cause_o is zero.
- R2: A counter adds exactly one on each clock in which its selected event input is high and its mode qualification holds.
- R3: Mode qualification works as follows. Control bit 0 counts when EXL or ERL is 1. Bit 1 counts in kernel mode, meaning KSU is 00 or EXL is 1 or ERL is 1. Bit 2 counts when KSU is 01 and EXL and ERL are both 0. Bit 3 counts when KSU is 10 and EXL and ERL are both 0. KSU equal to 11 enables only bits 0 and 1, through EXL or ERL.
- R4: A register write to a count in the same clock as an increment loads the written value, and the increment is lost.
- R5: Clearing control bits 4:0 stops the counter and keeps both its event selection and its count. Writing the earlier control value back makes counting resume.
- R6: irq_o and cause_o bit 26 are high exactly while some counter has control bit 4 (interrupt enable) set and count bit 31 set. Writing the count with bit 31 cleared drops them.
- R7: Control bit 31 reads 1 for indices below NUM_CNT-1 and 0 for the last present counter.
- R8: The event select field is control bits 14:5. Control bits 30:15 read zero whatever was written to them.
- R9: Register address bits 2:1 select the counter index, and bit 0 selects count (1) or control (0). An index at or above NUM_CNT reads zero and ignores writes.
- R10: An event select value at or above EVT_NUM never counts. The highest valid select, EVT_NUM-1, does count.
- R11: Writing zero to a control word and then to its count returns that channel to its reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ksu_i | input | 2 | Current privilege field: 00 kernel, 01 supervisor, 10 user |
| exl_i | input | 1 | Exception level flag |
| erl_i | input | 1 | Error level flag |
| evt_i | input | NUM_CNT*EVT_NUM | Event inputs, EVT_NUM bits per counter, counter 0 in the low bits |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | {counter index, count/control select} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Overflow interrupt request, level |
| cause_o | output | 32 | Cause image, bit 26 is the pending counter interrupt |

## Verification
A wrong mode decode or a wrong event select shows at the port as a count that differs from the number of qualified event cycles. This can be seen at the first read after the stimulus window. The bench sweeps privilege states against control masks so that each decode term is seen both counting and not counting. A stale or mis-prioritised count register shows in the very next cycle after a write that collides with an event. Interrupt state comes only from stored bits, so an error there is visible on irq_o one clock after the write or increment that causes it. Empty slots and reserved bits are checked by writing all ones and reading the value back.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int REG_W      = 32;
  localparam int MAX_CNT    = 4;
  localparam int IDX_W      = 2;
  localparam int SEL_W      = 10;
  localparam int CTL_LIVE_W = 15;   // bits 14:0 of the control word hold state
  localparam int MORE_BIT   = 31;
  localparam int PEND_BIT   = 26;

  // Ordered so that bit 0 is the exception-level enable, up to bit 3 (user).
  typedef struct packed {
    logic usr;
    logic sup;
    logic krn;
    logic exc;
  } mode_t;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             ie;
    mode_t            mode;
  } ctl_t;
endpackage

// File: rtl/pmc_mode_qual.sv
module pmc_mode_qual
  import pmc_pkg::*;
(
  input  logic [1:0] ksu_i,
  input  logic       exl_i,
  input  logic       erl_i,
  output mode_t      act_o
);
  logic at_exc;

  always_comb begin
    at_exc     = exl_i | erl_i;
    act_o.exc  = at_exc;
    act_o.krn  = at_exc | (ksu_i == 2'b00);
    act_o.sup  = ~at_exc & (ksu_i == 2'b01);
    act_o.usr  = ~at_exc & (ksu_i == 2'b10);
  end
endmodule

// File: rtl/pmc_channel.sv
module pmc_channel
  import pmc_pkg::*;
#(
  parameter int EVT_NUM = 16,
  parameter bit HAS_NEXT = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  mode_t              act_i,
  input  logic [EVT_NUM-1:0] evt_i,
  input  logic               ctl_we_i,
  input  logic               cnt_we_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   ctl_rd_o,
  output logic [REG_W-1:0]   cnt_o,
  output logic               pend_o
);
  localparam int EIDX_W = (EVT_NUM > 1) ? $clog2(EVT_NUM) : 1;
  localparam int PAD_W  = REG_W - 1 - CTL_LIVE_W;

  ctl_t             ctl_q, ctl_d;
  logic [REG_W-1:0] cnt_q, cnt_d;
  logic             ctl_en, cnt_en;
  logic             sel_ok, evt_hit, mode_ok, inc;

  // Next-state logic
  always_comb begin
    sel_ok  = (ctl_q.sel < SEL_W'(EVT_NUM));
    evt_hit = sel_ok & evt_i[ctl_q.sel[EIDX_W-1:0]];
    mode_ok = |(ctl_q.mode & act_i);
    inc     = evt_hit & mode_ok;

    ctl_en  = ctl_we_i;
    ctl_d   = ctl_t'(wdata_i[CTL_LIVE_W-1:0]);

    cnt_en  = cnt_we_i | inc;
    cnt_d   = cnt_we_i ? wdata_i : (cnt_q + REG_W'(1));
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    ctl_rd_o = {HAS_NEXT, {PAD_W{1'b0}}, ctl_q};
    cnt_o    = cnt_q;
    pend_o   = ctl_q.ie & cnt_q[REG_W-1];
  end
endmodule

// File: rtl/perf_count_unit.sv
module perf_count_unit
  import pmc_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int EVT_NUM = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 ksu_i,
  input  logic                       exl_i,
  input  logic                       erl_i,
  input  logic [NUM_CNT*EVT_NUM-1:0] evt_i,
  input  logic                       reg_we_i,
  input  logic [IDX_W:0]             reg_addr_i,
  input  logic [REG_W-1:0]           reg_wdata_i,
  output logic [REG_W-1:0]           reg_rdata_o,
  output logic                       irq_o,
  output logic [REG_W-1:0]           cause_o
);
  localparam logic [MAX_CNT-1:0] PRESENT = MAX_CNT'((1 << NUM_CNT) - 1);

  mode_t                     act;
  logic [IDX_W-1:0]          idx;
  logic                      is_cnt;
  logic                      hit;
  logic [MAX_CNT-1:0]        ctl_we, cnt_we, pend;
  logic [MAX_CNT*REG_W-1:0]  ctl_flat, cnt_flat;

  pmc_mode_qual u_qual (
    .ksu_i (ksu_i),
    .exl_i (exl_i),
    .erl_i (erl_i),
    .act_o (act)
  );

  always_comb begin
    idx    = reg_addr_i[IDX_W:1];
    is_cnt = reg_addr_i[0];
    hit    = PRESENT[idx];
    for (int k = 0; k < MAX_CNT; k++) begin
      ctl_we[k] = reg_we_i & hit & (idx == IDX_W'(k)) & ~is_cnt;
      cnt_we[k] = reg_we_i & hit & (idx == IDX_W'(k)) &  is_cnt;
    end
  end

  for (genvar i = 0; i < MAX_CNT; i++) begin : g_slot
    if (i < NUM_CNT) begin : g_ch
      pmc_channel #(
        .EVT_NUM  (EVT_NUM),
        .HAS_NEXT (i < NUM_CNT - 1)
      ) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_i    (act),
        .evt_i    (evt_i[i*EVT_NUM +: EVT_NUM]),
        .ctl_we_i (ctl_we[i]),
        .cnt_we_i (cnt_we[i]),
        .wdata_i  (reg_wdata_i),
        .ctl_rd_o (ctl_flat[i*REG_W +: REG_W]),
        .cnt_o    (cnt_flat[i*REG_W +: REG_W]),
        .pend_o   (pend[i])
      );
    end else begin : g_empty
      assign ctl_flat[i*REG_W +: REG_W] = '0;
      assign cnt_flat[i*REG_W +: REG_W] = '0;
      assign pend[i]                    = 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = is_cnt ? cnt_flat[idx*REG_W +: REG_W]
                         : ctl_flat[idx*REG_W +: REG_W];
    irq_o       = |pend;
    cause_o           = '0;
    cause_o[PEND_BIT] = irq_o;
  end
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int NUM_CNT = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we_i,
  input logic [2:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic [31:0] cnt0,
  input logic [4:0]  ctl0_run
);
  logic cnt0_wr;
  assign cnt0_wr = reg_we_i && (reg_addr_i == 3'd1);

  // R4: a write to count 0 always lands, whatever the event inputs did
  a_r4_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt0_wr |=> (cnt0 == $past(reg_wdata_i)));

  // R2: without a write, count 0 holds or steps by exactly one
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt0_wr |=> (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + 32'd1));

  // R5: with no mode enabled the count is frozen
  a_r5_paused_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl0_run[3:0] == 4'd0 && !cnt0_wr) |=> $stable(cnt0));

  // R7: the chain bit of control 0 tells whether a second counter exists
  a_r7_more_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == 3'd0) |-> (reg_rdata_o[31] == (NUM_CNT > 1)));

  // R8: reserved control bits read zero
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr_i[0] |-> (reg_rdata_o[30:15] == 16'd0));

  // R9: empty slots read zero
  a_r9_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr_i[2:1]) >= NUM_CNT) |-> (reg_rdata_o == 32'd0));
endmodule

bind perf_count_unit pmc_checker #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .cnt0        (cnt_flat[31:0]),
  .ctl0_run    (ctl_flat[4:0])
);

// File: tb/sim_perf_count_unit.sv
module sim_perf_count_unit;
  localparam int NC = 3;
  localparam int NE = 16;
  localparam logic [31:0] SEL3 = 32'd3 << 5;
  localparam logic [31:0] USR  = 32'h8;
  localparam logic [31:0] IEN  = 32'h10;

  // {ksu[1:0], exl, erl, ctl mode {u,s,k,e}, expected count}
  localparam logic [11:0] VEC [12] = '{
    12'h025, 12'h080, 12'h445, 12'h885, 12'hA25, 12'hA80,
    12'hA15, 12'h915, 12'hCE0, 12'h420, 12'h010, 12'h8F5
  };

  logic              clk, rst_n;
  logic [1:0]        ksu;
  logic              exl, erl;
  logic [NC*NE-1:0]  evt;
  logic              we;
  logic [2:0]        addr;
  logic [31:0]       wdata, rdata, cause;
  logic              irq;
  int                checks, errors;
  bit                done;
  logic [31:0]       v;

  perf_count_unit #(.NUM_CNT(NC), .EVT_NUM(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .ksu_i(ksu), .exl_i(exl), .erl_i(erl),
    .evt_i(evt), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .cause_o(cause)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Both tasks are entered just after a falling edge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; ksu = 2'b00; exl = 1'b0; erl = 1'b0;
    evt = '0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 ctl0", v, 32'h8000_0000);
    rd(3'd1, v); chk("R1 cnt0", v, 32'd0);
    rd(3'd5, v); chk("R1 cnt2", v, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 cause", cause, 32'd0);

    // R7 chain bit
    rd(3'd2, v); chk("R7 ctl1 more", {31'd0, v[31]}, 32'd1);
    rd(3'd4, v); chk("R7 ctl2 last", v, 32'd0);

    // R2/R3 table sweep on channel 0, event 3, five qualified cycles
    for (int r = 0; r < 12; r++) begin
      evt = '0;
      {ksu, exl, erl} = VEC[r][11:8];
      wr(3'd0, 32'(VEC[r][7:4]) | SEL3);
      wr(3'd1, 32'd0);
      evt[3] = 1'b1;
      repeat (5) @(negedge clk);
      evt = '0;
      rd(3'd1, v);
      chk($sformatf("R3 R2 row %0d", r), v, 32'(VEC[r][3:0]));
    end

    ksu = 2'b10; exl = 1'b0; erl = 1'b0;

    // R8 reserved bits
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R8 ctl1 readback", v, 32'h8000_7FFF);
    wr(3'd2, 32'd0);

    // R9 empty slot
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, v); chk("R9 ctl3 zero", v, 32'd0);
    rd(3'd7, v); chk("R9 cnt3 zero", v, 32'd0);
    rd(3'd4, v); chk("R9 ctl2 untouched", v, 32'd0);
    rd(3'd5, v); chk("R9 cnt2 untouched", v, 32'd0);

    // R10 select range
    evt = '0;
    wr(3'd0, USR | (32'd20 << 5));
    wr(3'd1, 32'd0);
    evt[NE-1:0] = '1;
    repeat (5) @(negedge clk);
    evt = '0;
    rd(3'd1, v); chk("R10 out of range", v, 32'd0);
    wr(3'd0, USR | (32'd15 << 5));
    wr(3'd1, 32'd0);
    evt[NE-1:0] = '1;
    repeat (3) @(negedge clk);
    evt = '0;
    rd(3'd1, v); chk("R10 top select", v, 32'd3);

    // R4 write beats increment
    wr(3'd0, USR | SEL3);
    wr(3'd1, 32'd0);
    evt[3] = 1'b1;
    repeat (2) @(negedge clk);
    wr(3'd1, 32'd100);
    rd(3'd1, v); chk("R4 write wins", v, 32'd100);
    @(negedge clk);
    rd(3'd1, v); chk("R4 resumes", v, 32'd101);

    // R5 pause and resume, events stay high throughout
    wr(3'd0, SEL3);
    rd(3'd1, v); chk("R5 last count", v, 32'd102);
    repeat (4) @(negedge clk);
    rd(3'd1, v); chk("R5 frozen", v, 32'd102);
    rd(3'd0, v); chk("R5 select kept", v, 32'h8000_0000 | SEL3);
    wr(3'd0, USR | SEL3);
    repeat (3) @(negedge clk);
    evt = '0;
    rd(3'd1, v); chk("R5 resumed", v, 32'd105);

    // R6 overflow interrupt
    wr(3'd0, USR | IEN | SEL3);
    wr(3'd1, 32'h7FFF_FFFE);
    chk("R6 idle irq", {31'd0, irq}, 32'd0);
    evt[3] = 1'b1;
    @(negedge clk);
    chk("R6 below top bit", {31'd0, irq}, 32'd0);
    @(negedge clk);
    evt = '0;
    rd(3'd1, v); chk("R6 count", v, 32'h8000_0000);
    chk("R6 irq raised", {31'd0, irq}, 32'd1);
    chk("R6 cause bit", cause, 32'h0400_0000);
    @(negedge clk);
    chk("R6 irq level held", {31'd0, irq}, 32'd1);
    wr(3'd1, v & 32'h7FFF_FFFF);
    chk("R6 irq cleared", {31'd0, irq}, 32'd0);
    chk("R6 cause cleared", cause, 32'd0);
    wr(3'd0, USR | SEL3);
    wr(3'd1, 32'h8000_0000);
    chk("R6 no enable", {31'd0, irq}, 32'd0);
    wr(3'd0, USR | IEN | SEL3);
    chk("R6 enable late", {31'd0, irq}, 32'd1);

    // R11 channel wipe
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd0);
    rd(3'd0, v); chk("R11 ctl0", v, 32'h8000_0000);
    rd(3'd1, v); chk("R11 cnt0", v, 32'd0);
    chk("R11 irq", {31'd0, irq}, 32'd0);

    finish_run();
  end
endmodule